// File: doc/BRIEF.md
# SAR Converter Calibration and Conversion Sequencer

This block is the clocked control unit of a 12-bit successive-approximation converter. After reset, or after a power-fail indication, it holds off all activity for a long settling interval. It then runs a fixed-length calibration phase that always ends in one automatic conversion. The analog array, the comparator and the trim arithmetic sit outside. During calibration the block only counts cycles and raises a calibration strobe.

A host starts a conversion with a rising edge on the active-low write strobe while chip select is low. Each conversion has two parts. The first is a 5-cycle acquisition window, in which the sample and auto-zero strobes are high. The second is a 12-cycle bit-trial phase that runs MSB first. In that phase the block drives a trial code to the capacitor array and reads a one-bit comparator. BUSY is active-low and stays low through settling, calibration and every conversion. The finished code is loaded into the result register in the same cycle that BUSY rises.

Calibration can be requested at any time in two ways: a sufficiently long low pulse on an asynchronous pin, or a register write with bit 1 set. A request abandons any conversion in progress.

FSM states:
- `ST_SETTLE`: power-up wait.
- `ST_CAL`: calibration.
- `ST_SAMPLE`: acquisition and auto-zero.
- `ST_TRIAL`: bit trials.
- `ST_IDLE`: result valid.

Transitions:
- SETTLE→CAL when the wait expires.
- CAL→SAMPLE when calibration ends.
- SAMPLE→TRIAL after 5 cycles.
- TRIAL→IDLE after 12 cycles.
- IDLE→SAMPLE on an accepted write.
- SAMPLE/TRIAL/IDLE→CAL on a calibration request.
- Any state→SETTLE on power-fail.

Top module: `sar_conv_sequencer`

## Requirements
- R1: After reset is released, `busy_n` is 0 and `cal_active_o` is 0 for exactly SETTLE_CYCLES (default 42425) clock cycles. `cal_active_o` goes to 1 on the following cycle. While reset is held, `busy_n`, `cal_active_o` and `result` are 0.
- R2: `cal_active_o` stays 1 for exactly CAL_CYCLES (default 168) cycles. A conversion then starts by itself: `sample_o` goes to 1 in the next cycle, and `busy_n` rises 17 cycles after calibration ends, with `result` holding the converted value.
- R3: A cycle with `pwr_fail` = 1 restarts the settling wait from zero. On the next cycle `busy_n`, `cal_active_o` and `sample_o` are 0, and calibration begins SETTLE_CYCLES cycles after that edge.
- R4: In the idle state, a conversion starts on the clock edge after `wr_n` goes from 0 to 1 with `cs_n` = 0. A rising `wr_n` with `cs_n` = 1 starts nothing.
- R5: A conversion lasts 17 cycles with `busy_n` = 0. `sample_o` and `autozero_o` are 1 in cycles 1 to 5. In cycle 6, `dac_code` equals 0x800, the MSB trial. In cycle 7, `dac_code[11]` holds the kept MSB and `dac_code[10]` = 1.
- R6: `comp_in` = 1 means the input is at or above the trial level, and the trial bit is kept; `comp_in` = 0 clears it. `result` equals the code of a comparator that reports input ≥ `dac_code`, including the codes 0x000 and 0xFFF.
- R7: `result` changes only in the cycle `busy_n` rises. During a conversion it keeps the previous value.
- R8: The `cal_n` pin passes through two synchroniser flops. A rising edge after at least CAL_MIN_LOW synchronised low cycles starts calibration: `cal_active_o` is 1 after the third clock edge following the release. A shorter pulse is ignored.
- R9: A write with `sfr_we` = 1 and `sfr_wdata[1]` = 1 starts calibration at that clock edge. A write with bit 1 = 0 has no effect.
- R10: A calibration request during a conversion abandons it at once. `busy_n` stays 0, `result` keeps its old value, and the following automatic conversion delivers the new value.
- R11: A write-strobe edge during settling or calibration is ignored. After the automatic conversion, `busy_n` stays 1.
- R12: A calibration request during settling or calibration is ignored. The phase in progress keeps its original length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Synchronous power-fail indication; restarts the settling wait |
| cal_n | input | 1 | Asynchronous active-low calibration request pin |
| sfr_we | input | 1 | Register write strobe |
| sfr_wdata | input | 8 | Register write data; bit 1 requests calibration |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; its rising edge starts a conversion |
| comp_in | input | 1 | Comparator: 1 when input ≥ trial level |
| busy_n | output | 1 | Active-low busy |
| sample_o | output | 1 | Sampling strobe |
| autozero_o | output | 1 | Comparator auto-zero strobe |
| cal_active_o | output | 1 | Calibration-phase strobe |
| dac_code | output | 12 | Trial code to the capacitor array |
| result | output | 12 | Last completed conversion code |

## Verification
Every result has a fixed latency, counted from the edge that registers the stimulus:
- A write edge shows `busy_n` low one edge later, and `busy_n` rises 17 edges after that.
- A register calibration request shows `cal_active_o` at the same edge.
- A `cal_n` release shows `cal_active_o` after three edges.
- Calibration turns into sampling after CAL_CYCLES edges, and settling turns into calibration after SETTLE_CYCLES edges.

The bench drives and samples only on falling clock edges. It steps a whole number of cycles to the edge where a change is due, and checks both the last cycle before the change and the first cycle after it.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_SETTLE,
        ST_CAL,
        ST_SAMPLE,
        ST_TRIAL,
        ST_IDLE
    } seq_state_t;
endpackage

// File: rtl/sar_seq_cal_filter.sv
// Two-flop synchroniser on the calibration pin plus a saturating low-width
// counter; a release is accepted only after MIN_LOW synchronised low cycles.
module sar_seq_cal_filter #(
    parameter int MIN_LOW = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_n,
    output logic cal_accept
);
    localparam int CNT_W = $clog2(MIN_LOW + 1);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MIN_LOW);

    logic             sync_q1;
    logic             sync_q2;
    logic             sync_prev;
    logic [CNT_W-1:0] low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q1   <= 1'b1;
            sync_q2   <= 1'b1;
            sync_prev <= 1'b1;
        end else begin
            sync_q1   <= cal_n;
            sync_q2   <= sync_q1;
            sync_prev <= sync_q2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (sync_q2) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_SAT) begin
            low_cnt <= low_cnt + CNT_W'(1);
        end
    end

    assign cal_accept = sync_q2 && !sync_prev && (low_cnt == CNT_SAT);
endmodule

// File: rtl/sar_seq_wr_edge.sv
// Detects the rising edge of the active-low write strobe qualified by select.
module sar_seq_wr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n,
    input  logic cs_n,
    output logic start_req
);
    logic wr_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_prev <= 1'b1;
        end else begin
            wr_prev <= wr_n;
        end
    end

    assign start_req = wr_n && !wr_prev && !cs_n;
endmodule

// File: rtl/sar_seq_sar_reg.sv
// Successive-approximation register: decides the current trial bit from the
// comparator and raises the next lower bit in the same step.
module sar_seq_sar_reg #(
    parameter int NBITS = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     arm,
    input  logic                     trial_en,
    input  logic [$clog2(NBITS)-1:0] bit_idx,
    input  logic                     comp_in,
    output logic [NBITS-1:0]         code,
    output logic [NBITS-1:0]         code_next
);
    localparam int IDX_W = $clog2(NBITS);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    always_comb begin
        code_next = code;
        if (trial_en) begin
            code_next[bit_idx] = comp_in;
            if (bit_idx != '0) begin
                code_next[bit_idx - IDX_W'(1)] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
        end else if (clear) begin
            code <= '0;
        end else if (arm) begin
            code <= MSB_ONLY;
        end else if (trial_en) begin
            code <= code_next;
        end
    end
endmodule

// File: rtl/sar_conv_sequencer.sv
module sar_conv_sequencer
    import sar_seq_pkg::*;
#(
    parameter int NBITS         = 12,
    parameter int SETTLE_CYCLES = 42425,
    parameter int CAL_CYCLES    = 168,
    parameter int SAMPLE_CYCLES = 5,
    parameter int CAL_MIN_LOW   = 20,
    parameter int SFR_W         = 8,
    parameter int SFR_CAL_BIT   = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_fail,
    input  logic             cal_n,
    input  logic             sfr_we,
    input  logic [SFR_W-1:0] sfr_wdata,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             comp_in,
    output logic             busy_n,
    output logic             sample_o,
    output logic             autozero_o,
    output logic             cal_active_o,
    output logic [NBITS-1:0] dac_code,
    output logic [NBITS-1:0] result
);
    localparam int IDX_W  = $clog2(NBITS);
    localparam int MAX_A  = (SETTLE_CYCLES > CAL_CYCLES) ? SETTLE_CYCLES : CAL_CYCLES;
    localparam int MAX_B  = (SAMPLE_CYCLES > NBITS) ? SAMPLE_CYCLES : NBITS;
    localparam int MAX_PH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W  = $clog2(MAX_PH + 1);

    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] CAL_LAST    = CNT_W'(CAL_CYCLES - 1);
    localparam logic [CNT_W-1:0] SAMPLE_LAST = CNT_W'(SAMPLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TRIAL_LAST  = CNT_W'(NBITS - 1);
    localparam logic [IDX_W-1:0] TOP_IDX     = IDX_W'(NBITS - 1);

    seq_state_t       state, state_next;
    logic [CNT_W-1:0] cnt, cnt_next;

    logic             pin_cal;
    logic             start_req;
    logic             sfr_cal;
    logic             cal_req;
    logic             sfr_unused;
    logic             sar_clear;
    logic             sar_arm;
    logic             sar_trial;
    logic [IDX_W-1:0] sar_idx;
    logic [NBITS-1:0] sar_next;
    logic             load_result;

    sar_seq_cal_filter #(
        .MIN_LOW(CAL_MIN_LOW)
    ) u_cal_filter (
        .clk       (clk),
        .rst_n     (rst_n),
        .cal_n     (cal_n),
        .cal_accept(pin_cal)
    );

    sar_seq_wr_edge u_wr_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_n     (wr_n),
        .cs_n     (cs_n),
        .start_req(start_req)
    );

    assign sfr_cal    = sfr_we && sfr_wdata[SFR_CAL_BIT];
    assign sfr_unused = ^sfr_wdata;
    assign cal_req    = sfr_cal || pin_cal;

    // Next-state and phase-counter decode
    always_comb begin
        state_next = state;
        cnt_next   = cnt;
        if (pwr_fail) begin
            state_next = ST_SETTLE;
            cnt_next   = '0;
        end else if (cal_req && (state == ST_SAMPLE || state == ST_TRIAL || state == ST_IDLE)) begin
            state_next = ST_CAL;
            cnt_next   = '0;
        end else begin
            unique case (state)
                ST_SETTLE: begin
                    if (cnt == SETTLE_LAST) begin
                        state_next = ST_CAL;
                        cnt_next   = '0;
                    end else begin
                        cnt_next = cnt + CNT_W'(1);
                    end
                end
                ST_CAL: begin
                    if (cnt == CAL_LAST) begin
                        state_next = ST_SAMPLE;
                        cnt_next   = '0;
                    end else begin
                        cnt_next = cnt + CNT_W'(1);
                    end
                end
                ST_SAMPLE: begin
                    if (cnt == SAMPLE_LAST) begin
                        state_next = ST_TRIAL;
                        cnt_next   = '0;
                    end else begin
                        cnt_next = cnt + CNT_W'(1);
                    end
                end
                ST_TRIAL: begin
                    if (cnt == TRIAL_LAST) begin
                        state_next = ST_IDLE;
                        cnt_next   = '0;
                    end else begin
                        cnt_next = cnt + CNT_W'(1);
                    end
                end
                ST_IDLE: begin
                    if (start_req) begin
                        state_next = ST_SAMPLE;
                        cnt_next   = '0;
                    end
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_SETTLE;
            cnt   <= '0;
        end else begin
            state <= state_next;
            cnt   <= cnt_next;
        end
    end

    // Outputs decoded from the current state
    always_comb begin
        busy_n       = 1'b0;
        sample_o     = 1'b0;
        autozero_o   = 1'b0;
        cal_active_o = 1'b0;
        unique case (state)
            ST_SETTLE: ;
            ST_CAL:    cal_active_o = 1'b1;
            ST_SAMPLE: begin
                sample_o   = 1'b1;
                autozero_o = 1'b1;
            end
            ST_TRIAL:  ;
            ST_IDLE:   busy_n = 1'b1;
        endcase
    end

    // Bit-trial control
    assign sar_clear   = (state_next == ST_CAL) || (state_next == ST_SETTLE);
    assign sar_arm     = (state == ST_SAMPLE) && (state_next == ST_TRIAL);
    assign sar_trial   = (state == ST_TRIAL) && (state_next != ST_CAL) && (state_next != ST_SETTLE);
    assign sar_idx     = TOP_IDX - cnt[IDX_W-1:0];
    assign load_result = (state == ST_TRIAL) && (state_next == ST_IDLE);

    sar_seq_sar_reg #(
        .NBITS(NBITS)
    ) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sar_clear),
        .arm      (sar_arm),
        .trial_en (sar_trial),
        .bit_idx  (sar_idx),
        .comp_in  (comp_in),
        .code     (dac_code),
        .code_next(sar_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load_result) begin
            result <= sar_next;
        end
    end
endmodule

// File: rtl/sar_conv_sequencer_chk.sv
module sar_conv_sequencer_chk #(
    parameter int NBITS = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_fail,
    input logic             busy_n,
    input logic             sample_o,
    input logic             autozero_o,
    input logic             cal_active_o,
    input logic [NBITS-1:0] dac_code,
    input logic [NBITS-1:0] result
);
    localparam logic [NBITS-1:0] MSB_ONLY = {1'b1, {(NBITS-1){1'b0}}};

    p_cal_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cal_active_o |-> !busy_n);

    p_cal_to_sample_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cal_active_o) && !$past(pwr_fail)) |-> sample_o);

    p_pfail_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> (!cal_active_o && !sample_o && !busy_n));

    p_sample_strobes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_o |-> (autozero_o && !busy_n && !cal_active_o));

    p_msb_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_o) && !$past(pwr_fail) && !cal_active_o) |-> (dac_code == MSB_ONLY));

    p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(busy_n) |-> $stable(result));
endmodule

bind sar_conv_sequencer sar_conv_sequencer_chk #(.NBITS(NBITS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_fail    (pwr_fail),
    .busy_n      (busy_n),
    .sample_o    (sample_o),
    .autozero_o  (autozero_o),
    .cal_active_o(cal_active_o),
    .dac_code    (dac_code),
    .result      (result)
);

// File: tb/sar_conv_sequencer_tb.sv
`timescale 1ns/1ps
module sar_conv_sequencer_tb;
    localparam int NB     = 12;
    localparam int SETTLE = 300;
    localparam int CAL    = 40;
    localparam int MINW   = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          pwr_fail;
    logic          cal_n;
    logic          sfr_we;
    logic [7:0]    sfr_wdata;
    logic          cs_n;
    logic          wr_n;
    logic          comp_in;
    logic          busy_n;
    logic          sample_o;
    logic          autozero_o;
    logic          cal_active_o;
    logic [NB-1:0] dac_code;
    logic [NB-1:0] result;
    logic [NB-1:0] ain;
    logic [NB-1:0] last_res;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // Comparator model: reports input at or above the trial level
    assign comp_in = (ain >= dac_code);

    sar_conv_sequencer #(
        .NBITS(NB), .SETTLE_CYCLES(SETTLE), .CAL_CYCLES(CAL),
        .SAMPLE_CYCLES(5), .CAL_MIN_LOW(MINW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .cal_n(cal_n),
        .sfr_we(sfr_we), .sfr_wdata(sfr_wdata), .cs_n(cs_n), .wr_n(wr_n),
        .comp_in(comp_in), .busy_n(busy_n), .sample_o(sample_o),
        .autozero_o(autozero_o), .cal_active_o(cal_active_o),
        .dac_code(dac_code), .result(result)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Called at the negedge right after calibration began
    task automatic finish_cal(input string tag);
        step(CAL - 1);
        chk({tag, " cal still active"}, cal_active_o, 1);
        step(1);
        chk({tag, " auto conversion sampling"}, {cal_active_o, sample_o}, 2'b01);
        step(16);
        chk({tag, " busy during auto conversion"}, busy_n, 0);
        step(1);
        chk({tag, " busy rises"}, busy_n, 1);
        chk({tag, " auto conversion result"}, result, ain);
        last_res = result;
    endtask

    task automatic pulse_wr();
        wr_n = 1'b0;
        step(1);
        wr_n = 1'b1;
    endtask

    task automatic t_reset_settle();
        rst_n = 1'b0;
        step(2);
        chk("R1 reset state", {busy_n, cal_active_o, 12'(result)}, 0);
        rst_n = 1'b1;
        step(SETTLE - 1);
        chk("R1 settle end no cal", {busy_n, cal_active_o}, 2'b00);
        step(1);
        chk("R1 cal starts", cal_active_o, 1);
        finish_cal("R2");
    endtask

    task automatic t_convert(input logic [NB-1:0] v);
        ain = v;
        pulse_wr();
        step(1);
        chk("R4 busy low after write edge", {busy_n, sample_o}, 2'b01);
        step(4);
        chk("R5 sample and autozero cycle 5", {sample_o, autozero_o}, 2'b11);
        step(1);
        chk("R5 msb trial code", {sample_o, 12'(dac_code)}, {1'b0, 12'h800});
        step(1);
        chk("R5 second trial bits", dac_code[11:10], {v[11], 1'b1});
        step(10);
        chk("R7 result held during conversion", {busy_n, 12'(result)}, {1'b0, 12'(last_res)});
        step(1);
        chk("R6 result code", {busy_n, 12'(result)}, {1'b1, 12'(v)});
        last_res = result;
    endtask

    task automatic t_cs_high();
        cs_n = 1'b1;
        pulse_wr();
        step(2);
        chk("R4 cs high ignored", busy_n, 1);
        cs_n = 1'b0;
    endtask

    task automatic t_cal_pin();
        cal_n = 1'b0;
        step(MINW - 1);
        cal_n = 1'b1;
        step(4);
        chk("R8 short pulse ignored", {busy_n, cal_active_o}, 2'b10);
        ain = 12'h3C7;
        cal_n = 1'b0;
        step(MINW);
        cal_n = 1'b1;
        step(2);
        chk("R8 no cal before sync delay", cal_active_o, 0);
        step(1);
        chk("R8 cal after long pulse", cal_active_o, 1);
        finish_cal("R8");
    endtask

    task automatic t_sfr();
        sfr_wdata = 8'hFD;
        sfr_we    = 1'b1;
        step(1);
        sfr_we = 1'b0;
        step(1);
        chk("R9 bit1 clear no effect", {busy_n, cal_active_o}, 2'b10);
        ain       = 12'h6E1;
        sfr_wdata = 8'h02;
        sfr_we    = 1'b1;
        step(1);
        sfr_we = 1'b0;
        chk("R9 register cal starts", cal_active_o, 1);
        finish_cal("R9");
    endtask

    task automatic t_abort();
        ain = 12'h955;
        pulse_wr();
        step(9);
        ain       = 12'h2B4;
        sfr_wdata = 8'h02;
        sfr_we    = 1'b1;
        step(1);
        sfr_we = 1'b0;
        chk("R10 abort into cal", {busy_n, cal_active_o}, 2'b01);
        chk("R10 result unchanged", result, last_res);
        // R12: extra request mid-calibration; R11: write edge mid-calibration
        step(5);
        sfr_we = 1'b1;
        step(1);
        sfr_we = 1'b0;
        pulse_wr();
        step(CAL - 8);
        chk("R12 cal length unchanged", cal_active_o, 1);
        step(1);
        chk("R12 cal ends on time", {cal_active_o, sample_o}, 2'b01);
        step(17);
        chk("R10 new value after abort", {busy_n, 12'(result)}, {1'b1, 12'(ain)});
        last_res = result;
        step(3);
        chk("R11 write during cal ignored", busy_n, 1);
    endtask

    task automatic t_pfail();
        pwr_fail = 1'b1;
        step(1);
        pwr_fail = 1'b0;
        chk("R3 pfail busy and strobes", {busy_n, cal_active_o, sample_o}, 3'b000);
        pulse_wr();
        sfr_wdata = 8'h02;
        sfr_we    = 1'b1;
        step(1);
        sfr_we = 1'b0;
        step(SETTLE - 3);
        chk("R12 settle not cut short", {busy_n, cal_active_o, sample_o}, 3'b000);
        step(1);
        chk("R3 cal after restart", cal_active_o, 1);
        ain = 12'hC0F;
        finish_cal("R3");
        step(3);
        chk("R11 write during settle ignored", busy_n, 1);
    endtask

    initial begin
        rst_n     = 1'b0;
        pwr_fail  = 1'b0;
        cal_n     = 1'b1;
        sfr_we    = 1'b0;
        sfr_wdata = 8'h00;
        cs_n      = 1'b0;
        wr_n      = 1'b1;
        ain       = 12'h5A3;
        last_res  = '0;
        step(1);
        t_reset_settle();
        t_convert(12'hABC);
        t_convert(12'h000);
        t_convert(12'hFFF);
        t_convert(12'h001);
        t_convert(12'h800);
        t_cs_high();
        t_cal_pin();
        t_sfr();
        t_abort();
        t_pfail();
        t_convert(12'h7FF);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule